// File: doc/BRIEF.md
# Power Domain Gating Sequencer

This block takes a switchable logic domain out of and back into service in a safe order. For every domain channel it drives three signals: an isolation enable that clamps the domain's outputs, a power-switch-open control, and a domain-off status flag. Software controls the block through a small memory-mapped register port. It sets a request bit in a shared control word, and the matching channel then steps through a two-phase timed sequence. When the sequence finishes, the channel clears its own request bits.

There are two identical channels. Channel 0 serves a graphics/video domain and channel 1 serves a CPU domain. Each channel has a gate-enable register, a power-up timing register and a power-down timing register. Every timing register holds two 6-bit phase delays, counted in register-port clock cycles. A power-down request only removes power when the channel's gate-enable bit is set.

Reads return data one cycle after the read strobe. Writes take effect on the clock edge where the write strobe is sampled.

Top module: `pwr_gate_seq`

## Requirements
- R1: After reset every channel has isolation_en=0, switch_off=0 and domain_off=0 (the domain is powered), and every register reads 0.
- R2: Power-down, with gate enable set and the domain on, is requested by writing 1 to control bit 2*ch (channel ch). The write is sampled at edge E0, with per-phase length m(x)=max(x,1). Isolation_en rises at edge E0+1+m(A), where A is bits [5:0] of the power-down timing register. Switch_off and domain_off rise together at edge E0+1+m(A)+m(B), where B is bits [13:8].
- R3: Power-up, with the domain off, is requested by writing 1 to control bit 2*ch+1. Switch_off falls at edge E0+1. Isolation_en and domain_off fall together at edge E0+1+m(C)+m(D), where C is bits [5:0] and D is bits [13:8] of the power-up timing register.
- R4: If bit 0 of the gate-enable register is 0, a power-down request changes no output and its request bit reads 0 afterwards.
- R5: A request bit reads 1 while its sequence runs and clears itself when the sequence ends. Writing 0 to a request bit has no effect.
- R6: When both request bits of a channel are set, power-up wins and both bits clear at its end.
- R7: A request that matches the domain's current state changes no output and clears on the next edge.
- R8: Register offsets are: control 0x000; channel ch at base 0x260+0x40*ch, with gate enable at base+0, power-up timing at base+4 and power-down timing at base+8. Only implemented bits read back; other bits read 0. Reads of undefined offsets return 0, and writes to them change nothing.
- R9: A sequence on one channel leaves the other channel's outputs unchanged.
- R10: Switch_off is only ever 1 while isolation_en and domain_off are both 1. Isolation rises at least one cycle before the switch opens. Isolation falls only while the switch is already closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register-port and sequencer clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; data is valid on the next cycle |
| bus_addr | input | ADDR_W | Byte offset |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| iso_en | output | NCH | Per-channel isolation enable |
| sw_off | output | NCH | Per-channel power-switch open |
| dom_off | output | NCH | Per-channel domain-off status |

## Verification
A stuck or misrouted channel state shows at the ports as an isolation or switch edge that comes early, late or never. The bench measures the arrival cycle of each edge against the delay fields, so an off-by-one in a phase counter shows up within one sequence. A request bit that fails to clear shows on the next control read. A wrong priority decision appears as the domain staying off when both requests are written. Ordering faults between isolation and the switch are caught on the very edge where they happen.

// File: rtl/pgs_pkg.sv
package pgs_pkg;
  localparam int CTRL_OFF   = 'h000;
  localparam int CH_BASE    = 'h260;
  localparam int CH_STRIDE  = 'h040;
  localparam int GATE_OFF   = 0;
  localparam int UPTM_OFF   = 4;
  localparam int DNTM_OFF   = 8;
  localparam int SECOND_LSB = 8;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DN_ISO,
    ST_DN_SW,
    ST_UP_SW,
    ST_UP_ISO
  } chan_st_e;
endpackage

// File: rtl/pgs_regs.sv
module pgs_regs import pgs_pkg::*; #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DLY_W  = 6,
  parameter int NCH    = 2
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       bus_wr,
  input  logic                       bus_rd,
  input  logic [ADDR_W-1:0]          bus_addr,
  input  logic [DATA_W-1:0]          bus_wdata,
  output logic [DATA_W-1:0]          bus_rdata,
  input  logic [NCH-1:0]             ack,
  output logic [NCH-1:0]             req_dn,
  output logic [NCH-1:0]             req_up,
  output logic [NCH-1:0]             gate_en,
  output logic [NCH-1:0][DLY_W-1:0]  dn_first,
  output logic [NCH-1:0][DLY_W-1:0]  dn_second,
  output logic [NCH-1:0][DLY_W-1:0]  up_first,
  output logic [NCH-1:0][DLY_W-1:0]  up_second
);
  function automatic logic [ADDR_W-1:0] ch_addr(int ch, int off);
    return ADDR_W'(CH_BASE + ch * CH_STRIDE + off);
  endfunction

  logic              wr_ctrl;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_wdata;

  assign wr_ctrl      = bus_wr && (bus_addr == ADDR_W'(CTRL_OFF));
  assign unused_wdata = ^bus_wdata;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_dn    <= '0;
      req_up    <= '0;
      gate_en   <= '0;
      dn_first  <= '0;
      dn_second <= '0;
      up_first  <= '0;
      up_second <= '0;
      bus_rdata <= '0;
    end else begin
      for (int i = 0; i < NCH; i++) begin
        req_dn[i] <= (req_dn[i] & ~ack[i]) | (wr_ctrl & bus_wdata[2*i]);
        req_up[i] <= (req_up[i] & ~ack[i]) | (wr_ctrl & bus_wdata[2*i+1]);
        if (bus_wr && bus_addr == ch_addr(i, GATE_OFF))
          gate_en[i] <= bus_wdata[0];
        if (bus_wr && bus_addr == ch_addr(i, UPTM_OFF)) begin
          up_first[i]  <= bus_wdata[DLY_W-1:0];
          up_second[i] <= bus_wdata[SECOND_LSB +: DLY_W];
        end
        if (bus_wr && bus_addr == ch_addr(i, DNTM_OFF)) begin
          dn_first[i]  <= bus_wdata[DLY_W-1:0];
          dn_second[i] <= bus_wdata[SECOND_LSB +: DLY_W];
        end
      end
      if (bus_rd)
        bus_rdata <= rd_mux;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (bus_addr == ADDR_W'(CTRL_OFF)) begin
      for (int i = 0; i < NCH; i++) begin
        rd_mux[2*i]   = req_dn[i];
        rd_mux[2*i+1] = req_up[i];
      end
    end
    for (int i = 0; i < NCH; i++) begin
      if (bus_addr == ch_addr(i, GATE_OFF))
        rd_mux[0] = gate_en[i];
      if (bus_addr == ch_addr(i, UPTM_OFF)) begin
        rd_mux[DLY_W-1:0]           = up_first[i];
        rd_mux[SECOND_LSB +: DLY_W] = up_second[i];
      end
      if (bus_addr == ch_addr(i, DNTM_OFF)) begin
        rd_mux[DLY_W-1:0]           = dn_first[i];
        rd_mux[SECOND_LSB +: DLY_W] = dn_second[i];
      end
    end
  end
endmodule

// File: rtl/pgs_chan.sv
module pgs_chan import pgs_pkg::*; #(
  parameter int DLY_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_dn,
  input  logic             req_up,
  input  logic             gate_en,
  input  logic [DLY_W-1:0] dn_first,
  input  logic [DLY_W-1:0] dn_second,
  input  logic [DLY_W-1:0] up_first,
  input  logic [DLY_W-1:0] up_second,
  output logic             ack,
  output logic             iso_en,
  output logic             sw_off,
  output logic             dom_off
);
  chan_st_e         st;
  logic [DLY_W-1:0] cnt;
  logic             last;

  // A zero field still gives a one-cycle phase.
  assign last = (cnt <= DLY_W'(1));

  always_comb begin
    ack = 1'b0;
    case (st)
      ST_IDLE: begin
        if (req_up)      ack = !dom_off;
        else if (req_dn) ack = dom_off || !gate_en;
      end
      ST_DN_SW:  ack = last;
      ST_UP_ISO: ack = last;
      default:   ack = 1'b0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      cnt     <= '0;
      iso_en  <= 1'b0;
      sw_off  <= 1'b0;
      dom_off <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (req_up && dom_off) begin
            sw_off <= 1'b0;
            cnt    <= up_first;
            st     <= ST_UP_SW;
          end else if (!req_up && req_dn && !dom_off && gate_en) begin
            cnt <= dn_first;
            st  <= ST_DN_ISO;
          end
        end
        ST_DN_ISO: begin
          if (last) begin
            iso_en <= 1'b1;
            cnt    <= dn_second;
            st     <= ST_DN_SW;
          end else cnt <= cnt - 1'b1;
        end
        ST_DN_SW: begin
          if (last) begin
            sw_off  <= 1'b1;
            dom_off <= 1'b1;
            st      <= ST_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        ST_UP_SW: begin
          if (last) begin
            cnt <= up_second;
            st  <= ST_UP_ISO;
          end else cnt <= cnt - 1'b1;
        end
        ST_UP_ISO: begin
          if (last) begin
            iso_en  <= 1'b0;
            dom_off <= 1'b0;
            st      <= ST_IDLE;
          end else cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/pwr_gate_seq.sv
module pwr_gate_seq #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 32,
  parameter int DLY_W  = 6,
  parameter int NCH    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic [NCH-1:0]    iso_en,
  output logic [NCH-1:0]    sw_off,
  output logic [NCH-1:0]    dom_off
);
  logic [NCH-1:0]            ack, req_dn, req_up, gate_en;
  logic [NCH-1:0][DLY_W-1:0] dn_first, dn_second, up_first, up_second;

  pgs_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .DLY_W(DLY_W), .NCH(NCH)) u_regs (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ack(ack), .req_dn(req_dn), .req_up(req_up), .gate_en(gate_en),
    .dn_first(dn_first), .dn_second(dn_second),
    .up_first(up_first), .up_second(up_second)
  );

  for (genvar g = 0; g < NCH; g++) begin : g_chan
    pgs_chan #(.DLY_W(DLY_W)) u_chan (
      .clk(clk), .rst(rst),
      .req_dn(req_dn[g]), .req_up(req_up[g]), .gate_en(gate_en[g]),
      .dn_first(dn_first[g]), .dn_second(dn_second[g]),
      .up_first(up_first[g]), .up_second(up_second[g]),
      .ack(ack[g]), .iso_en(iso_en[g]), .sw_off(sw_off[g]), .dom_off(dom_off[g])
    );
  end
endmodule

// File: rtl/pwr_gate_seq_chk.sv
module pwr_gate_seq_chk #(
  parameter int DATA_W = 32,
  parameter int NCH    = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NCH-1:0]    iso_en,
  input logic [NCH-1:0]    sw_off,
  input logic [NCH-1:0]    dom_off
);
  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (iso_en == '0 && sw_off == '0 && dom_off == '0 && bus_rdata == '0));

  for (genvar g = 0; g < NCH; g++) begin : g_prop
    p_switch_needs_iso_r10: assert property (@(posedge clk) disable iff (rst)
      sw_off[g] |-> (iso_en[g] && dom_off[g]));
    p_iso_before_switch_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(sw_off[g]) |-> $past(iso_en[g]));
    p_off_with_switch_r2: assert property (@(posedge clk) disable iff (rst)
      $rose(dom_off[g]) |-> sw_off[g]);
    p_release_after_close_r3: assert property (@(posedge clk) disable iff (rst)
      $fell(iso_en[g]) |-> $past(!sw_off[g]));
  end
endmodule

bind pwr_gate_seq pwr_gate_seq_chk #(.DATA_W(DATA_W), .NCH(NCH)) u_chk (
  .clk(clk), .rst(rst), .bus_rdata(bus_rdata),
  .iso_en(iso_en), .sw_off(sw_off), .dom_off(dom_off)
);

// File: tb/pwr_gate_seq_tb.sv
module pwr_gate_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int NCH    = 2;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bus_wr = 1'b0, bus_rd = 1'b0;
  logic [ADDR_W-1:0] bus_addr = '0;
  logic [DATA_W-1:0] bus_wdata = '0;
  logic [DATA_W-1:0] bus_rdata;
  logic [NCH-1:0]    iso_en, sw_off, dom_off;

  int n_checks = 0;
  int n_fail   = 0;

  pwr_gate_seq u_dut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .iso_en(iso_en), .sw_off(sw_off), .dom_off(dom_off)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fail++;
    $display("FAIL watchdog: run did not finish, actual hung expected done");
    summary();
    $finish;
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int ph(input int x);
    return (x == 0) ? 1 : x;
  endfunction

  function automatic logic [ADDR_W-1:0] base(input int ch);
    return ADDR_W'(12'h260 + ch * 12'h40);
  endfunction

  task automatic bus_write(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  // Cycle numbers (from the edge after the write edge) of first change per output.
  task automatic watch(input int ch, input int lim,
                       output int ti, output int ts, output int to, output bit other);
    logic i0, s0, o0;
    logic [2:0] oth0;
    int oc;
    oc = 1 - ch;
    i0 = iso_en[ch]; s0 = sw_off[ch]; o0 = dom_off[ch];
    oth0 = {iso_en[oc], sw_off[oc], dom_off[oc]};
    ti = 0; ts = 0; to = 0; other = 1'b0;
    for (int k = 1; k <= lim; k++) begin
      @(negedge clk);
      if (ti == 0 && iso_en[ch]  != i0) ti = k;
      if (ts == 0 && sw_off[ch]  != s0) ts = k;
      if (to == 0 && dom_off[ch] != o0) to = k;
      if ({iso_en[oc], sw_off[oc], dom_off[oc]} != oth0) other = 1'b1;
    end
  endtask

  task automatic run_down(input int ch, input int a, input int b);
    int ti, ts, to, expi, expo;
    bit other;
    logic [DATA_W-1:0] r;
    bus_write(base(ch) + 12'd8, DATA_W'((b << 8) | a));
    bus_write(base(ch), 32'h1);
    bus_write(12'h000, DATA_W'(1 << (2*ch)));
    watch(ch, 140, ti, ts, to, other);
    expi = 1 + ph(a);
    expo = 1 + ph(a) + ph(b);
    check(ti == expi, "R2 isolation rise cycle", ti, expi);
    check(to == expo && ts == expo, "R2 switch/off rise cycle", to, expo);
    check(ti < ts, "R10 isolation before switch", ti, ts);
    check(dom_off[ch] && iso_en[ch] && sw_off[ch], "R2 final off state", dom_off[ch], 1);
    check(!other, "R9 other channel untouched", other, 0);
    bus_read(12'h000, r);
    check(r == '0, "R5 request self-clear after down", int'(r), 0);
  endtask

  task automatic run_up(input int ch, input int c, input int d);
    int ti, ts, to, expo;
    bit other;
    logic [DATA_W-1:0] r;
    bus_write(base(ch) + 12'd4, DATA_W'((d << 8) | c));
    bus_write(12'h000, DATA_W'(2 << (2*ch)));
    watch(ch, 140, ti, ts, to, other);
    expo = 1 + ph(c) + ph(d);
    check(ts == 1, "R3 switch close cycle", ts, 1);
    check(ti == expo && to == expo, "R3 isolation/off fall cycle", ti, expo);
    check(ts < ti, "R10 switch closed before release", ts, ti);
    check(!dom_off[ch] && !iso_en[ch] && !sw_off[ch], "R3 final on state", dom_off[ch], 0);
    check(!other, "R9 other channel untouched", other, 0);
    bus_read(12'h000, r);
    check(r == '0, "R5 request self-clear after up", int'(r), 0);
  endtask

  initial begin
    logic [DATA_W-1:0] r;
    int ti, ts, to;
    bit other;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    check(iso_en == '0 && sw_off == '0 && dom_off == '0, "R1 outputs after reset",
          int'({iso_en, sw_off, dom_off}), 0);
    for (int ch = 0; ch < NCH; ch++) begin
      bus_read(base(ch) + 12'd4, r); check(r == '0, "R1 up timing reset", int'(r), 0);
      bus_read(base(ch) + 12'd8, r); check(r == '0, "R1 down timing reset", int'(r), 0);
      bus_read(base(ch), r);         check(r == '0, "R1 gate enable reset", int'(r), 0);
    end
    bus_read(12'h000, r); check(r == '0, "R1 control reset", int'(r), 0);

    // R8 readback, unused bits and undefined offsets
    bus_write(base(0) + 12'd4, 32'hFFFF_FFFF);
    bus_read(base(0) + 12'd4, r);
    check(r == 32'h3F3F, "R8 up timing field mask", int'(r), 32'h3F3F);
    bus_write(base(1), 32'hFFFF_FFFE);
    bus_read(base(1), r);
    check(r == 32'h0, "R8 gate enable bit0 only", int'(r), 0);
    bus_write(12'h004, 32'hFFFF_FFFF);
    bus_read(12'h004, r);
    check(r == '0, "R8 undefined offset reads zero", int'(r), 0);
    bus_read(12'h26C, r);
    check(r == '0, "R8 undefined channel offset", int'(r), 0);
    bus_read(12'h000, r);
    check(r == '0, "R8 undefined write left control", int'(r), 0);
    check(dom_off == '0 && iso_en == '0, "R8 undefined write no output effect",
          int'(dom_off), 0);

    // R4 gate enable clear
    bus_write(base(0), 32'h0);
    bus_write(12'h000, 32'h1);
    watch(0, 20, ti, ts, to, other);
    check(ti == 0 && ts == 0 && to == 0, "R4 no change without gate enable", ti + ts + to, 0);
    bus_read(12'h000, r);
    check(r == '0, "R4 request cleared", int'(r), 0);

    // R7 matching request (domain on, power-up)
    bus_write(12'h000, 32'h2);
    watch(0, 20, ti, ts, to, other);
    check(ti == 0 && ts == 0 && to == 0, "R7 up while on no change", ti + ts + to, 0);
    bus_read(12'h000, r);
    check(r == '0, "R7 up request cleared", int'(r), 0);

    // R6 both while on: power-up wins, nothing happens
    bus_write(base(0), 32'h1);
    bus_write(12'h000, 32'h3);
    watch(0, 20, ti, ts, to, other);
    check(to == 0 && ti == 0, "R6 both while on stays on", to, 0);
    bus_read(12'h000, r);
    check(r == '0, "R6 both cleared while on", int'(r), 0);

    // Directed zero-delay corners
    run_down(0, 0, 0);
    run_up(0, 0, 0);

    // R5 write of 0 during a long sequence
    bus_write(base(1) + 12'd8, 32'h2828);
    bus_write(base(1), 32'h1);
    bus_write(12'h000, 32'h4);
    bus_write(12'h000, 32'h0);
    bus_read(12'h000, r);
    check(r == 32'h4, "R5 bit held while running", int'(r), 4);
    repeat (100) @(negedge clk);
    check(dom_off[1] == 1'b1, "R5 sequence completed", dom_off[1], 1);
    check(dom_off[0] == 1'b0, "R9 gfx stayed on", dom_off[0], 0);
    bus_read(12'h000, r);
    check(r == '0, "R5 bit cleared at end", int'(r), 0);

    // R7 matching request (domain off, power-down)
    bus_write(12'h000, 32'h4);
    watch(1, 20, ti, ts, to, other);
    check(ti == 0 && ts == 0 && to == 0, "R7 down while off no change", ti + ts + to, 0);

    // R6 both while off: power-up wins
    bus_write(base(1) + 12'd4, 32'h0302);
    bus_write(12'h000, 32'hC);
    watch(1, 40, ti, ts, to, other);
    check(to == 1 + 2 + 3, "R6 up wins when both set", to, 6);
    check(dom_off[1] == 1'b0, "R6 domain powered", dom_off[1], 0);
    bus_read(12'h000, r);
    check(r == '0, "R6 both bits cleared", int'(r), 0);

    // Directed mid values, then constrained random delays on both channels
    run_down(1, 5, 7);
    run_up(1, 7, 5);
    for (int it = 0; it < 8; it++) begin
      int ch, a, b, c, d;
      ch = int'($urandom_range(1, 0));
      a = int'($urandom_range(63, 0)); b = int'($urandom_range(63, 0));
      c = int'($urandom_range(63, 0)); d = int'($urandom_range(63, 0));
      run_down(ch, a, b);
      run_up(ch, c, d);
    end
    run_down(0, 63, 63);
    run_up(0, 63, 1);

    summary();
    $finish;
  end
endmodule